// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a 32-lane SIMD thread are allowed to commit results while that thread runs through predicated, possibly nested, if/else regions. Every lane executes every instruction; the active mask alone decides whose results are kept. Each cycle the block accepts a per-lane predicate vector and a two-bit operation code. The operations are: enter a divergent branch (push), switch to the other path (flip), leave the region (join), or do nothing.

On a push the current mask is saved on an internal stack. The new mask becomes the current mask narrowed by the predicate. A flip selects the lanes of the saved parent mask that were not on the path just finished. A join restores the saved parent mask. Stack depth is a parameter. Misuse does not corrupt state. A push on a full stack, or a join or flip on an empty one, leaves mask and stack untouched and raises a one-cycle error flag. A zero mask is reported so that a sequencer can skip a path that no lane takes.

Top module: `divg_mask_stack`

## Requirements
- R1: During and right after synchronous reset the active mask is all ones, both error flags are low and the stack is empty.
- R2: Operation code 2'b01 (push) with fewer than DEPTH saved entries saves the current mask and sets the mask to the current mask AND the predicate on the following cycle.
- R3: Operation code 2'b10 (flip) with a non-empty stack sets the mask to the top saved mask AND NOT the current mask, and it leaves the stack unchanged.
- R4: Operation code 2'b11 (join) with a non-empty stack restores the most recently saved mask and removes it. Nested pushes are restored in last-in, first-out order, up to DEPTH levels.
- R5: A push with DEPTH entries saved raises the overflow flag for exactly the next cycle. The mask and all saved entries stay unchanged.
- R6: A join on an empty stack raises the underflow flag for exactly the next cycle and leaves the mask unchanged.
- R7: A flip on an empty stack raises the underflow flag for exactly the next cycle and leaves the mask unchanged.
- R8: The commit-enable vector equals the active mask in every cycle. Lane i commits only when bit i is set.
- R9: The all-inactive output is high exactly when the active mask is zero.
- R10: Operation code 2'b00 (none) leaves the mask and the stack unchanged, and both error flags are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_i | input | LANES | Per-lane branch predicate, 1 = lane takes the first path |
| op_i | input | 2 | 00 none, 01 push, 10 flip, 11 join |
| act_mask_o | output | LANES | Current active-lane mask |
| commit_en_o | output | LANES | Per-lane result commit enable |
| ovf_o | output | 1 | Push rejected because the stack was full (one cycle) |
| udf_o | output | 1 | Join or flip rejected because the stack was empty (one cycle) |
| all_off_o | output | 1 | No lane is active; the current path may be skipped |

## Verification
The embedded properties rely on the operation code being one of the four defined values and on the predicate being sampled only in a push cycle, where any value is legal. They also rely on the stack-state signals that the mask logic sees being the ones the storage drives in the same cycle. The stimulus therefore drives a mix of all four codes with arbitrary predicates. It includes misuse at both stack limits, a nesting run to full depth with one extra push, and unwinding down to an empty stack with one extra join and flip. A reference model in the bench tracks the expected mask and stack, so no input pattern is excluded.

// File: rtl/divg_pkg.sv
package divg_pkg;

    localparam int DEF_LANES = 32;
    localparam int DEF_DEPTH = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PUSH = 2'b01,
        OP_FLIP = 2'b10,
        OP_JOIN = 2'b11
    } lane_op_e;

    typedef struct packed {
        logic push_ok;
        logic flip_ok;
        logic join_ok;
        logic ovf;
        logic udf;
    } op_decode_t;

    function automatic op_decode_t decode_op(lane_op_e op, logic full, logic empty);
        op_decode_t d;
        d.push_ok = (op == OP_PUSH) && !full;
        d.flip_ok = (op == OP_FLIP) && !empty;
        d.join_ok = (op == OP_JOIN) && !empty;
        d.ovf     = (op == OP_PUSH) && full;
        d.udf     = ((op == OP_FLIP) || (op == OP_JOIN)) && empty;
        return d;
    endfunction

endpackage

// File: rtl/divg_stack.sv
module divg_stack #(
    parameter int LANES = divg_pkg::DEF_LANES,
    parameter int DEPTH = divg_pkg::DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic             pop_en,
    input  logic [LANES-1:0] push_data,
    output logic [LANES-1:0] top,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] sp_m1;
    logic [LANES-1:0] mem [DEPTH];

    assign full  = (sp == PTR_W'(DEPTH));
    assign empty = (sp == '0);
    assign sp_m1 = sp - PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            sp <= '0;
        else if (push_en)
            sp <= sp + PTR_W'(1);
        else if (pop_en)
            sp <= sp_m1;
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= '0;
                else if (push_en && (sp == PTR_W'(i)))
                    mem[i] <= push_data;
            end
        end
    endgenerate

    assign top = empty ? '1 : mem[sp_m1[IDX_W-1:0]];

    // R5: the mask logic never requests a push into a full stack
    a_r5_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push_en |-> !full);
    // R6: the mask logic never requests a pop from an empty stack
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> !empty);
    // R2: an accepted push makes the saved entry visible as the new top
    a_r2_push_top: assert property (@(posedge clk) disable iff (rst)
        push_en |=> (top == $past(push_data)));
    // R3: a cycle with no push and no pop keeps the top entry
    a_r3_top_hold: assert property (@(posedge clk) disable iff (rst)
        (!push_en && !pop_en) |=> $stable(top));

endmodule

// File: rtl/divg_mask_unit.sv
module divg_mask_unit
    import divg_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_op_e         op,
    input  logic [LANES-1:0] pred,
    input  logic [LANES-1:0] top,
    input  logic             full,
    input  logic             empty,
    output logic             push_en,
    output logic             pop_en,
    output logic [LANES-1:0] mask,
    output logic             ovf,
    output logic             udf
);
    op_decode_t       dec;
    logic [LANES-1:0] mask_nx;

    assign dec     = decode_op(op, full, empty);
    assign push_en = dec.push_ok;
    assign pop_en  = dec.join_ok;

    always_comb begin
        mask_nx = mask;
        if (dec.push_ok)
            mask_nx = mask & pred;
        else if (dec.flip_ok)
            mask_nx = top & ~mask;
        else if (dec.join_ok)
            mask_nx = top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
            ovf  <= 1'b0;
            udf  <= 1'b0;
        end else begin
            mask <= mask_nx;
            ovf  <= dec.ovf;
            udf  <= dec.udf;
        end
    end

    // R2: an accepted push only removes lanes, never adds them
    a_r2_push_narrows: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH && !full) |=> ((mask & ~$past(mask)) == '0));
    // R3: flip result lies inside the parent and outside the finished path
    a_r3_flip_inside_parent: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FLIP && !empty) |=> (((mask & ~$past(top)) == '0) && ((mask & $past(mask)) == '0)));
    // R4: join restores the saved parent
    a_r4_join_restores: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JOIN && !empty) |=> (mask == $past(top)));
    // R5: rejected push flags overflow and keeps the mask
    a_r5_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH && full) |=> (ovf && $stable(mask)));
    // R6, R7: rejected join or flip flags underflow and keeps the mask
    a_r6_udf_hold: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_JOIN || op == OP_FLIP) && empty) |=> (udf && $stable(mask)));
    // R10: no operation keeps the mask and clears both flags
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE) |=> ($stable(mask) && !ovf && !udf));
    // R5: the two error flags never coincide
    a_r5_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(ovf && udf));

endmodule

// File: rtl/divg_mask_stack.sv
module divg_mask_stack
    import divg_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] pred_i,
    input  logic [1:0]       op_i,
    output logic [LANES-1:0] act_mask_o,
    output logic [LANES-1:0] commit_en_o,
    output logic             ovf_o,
    output logic             udf_o,
    output logic             all_off_o
);
    lane_op_e         op;
    logic [LANES-1:0] top;
    logic             full;
    logic             empty;
    logic             push_en;
    logic             pop_en;
    logic [LANES-1:0] mask;

    assign op = lane_op_e'(op_i);

    divg_mask_unit #(.LANES(LANES)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .pred    (pred_i),
        .top     (top),
        .full    (full),
        .empty   (empty),
        .push_en (push_en),
        .pop_en  (pop_en),
        .mask    (mask),
        .ovf     (ovf_o),
        .udf     (udf_o)
    );

    divg_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en),
        .pop_en    (pop_en),
        .push_data (mask),
        .top       (top),
        .full      (full),
        .empty     (empty)
    );

    assign act_mask_o  = mask;
    assign commit_en_o = mask;
    assign all_off_o   = ~|mask;

    // R1: the cycle after reset starts with every lane active
    a_r1_reset_ones: assert property (@(posedge clk)
        rst |=> (act_mask_o == '1 && !ovf_o && !udf_o));

endmodule

// File: tb/sim_divg_mask_stack.sv
`timescale 1ns/1ps
module sim_divg_mask_stack;
    localparam int LANES = 32;
    localparam int DEPTH = 8;

    typedef struct {
        int          cyc;
        logic [31:0] mask;
        logic        ovf;
        logic        udf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pred_i = '0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] act_mask_o, commit_en_o;
    logic        ovf_o, udf_o, all_off_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    exp_t        sb[$];
    logic [31:0] m_mask;
    logic [31:0] m_stk[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    divg_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .pred_i(pred_i), .op_i(op_i),
        .act_mask_o(act_mask_o), .commit_en_o(commit_en_o),
        .ovf_o(ovf_o), .udf_o(udf_o), .all_off_o(all_off_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one operation and records the model's expectation
    task automatic step(logic [1:0] op, logic [31:0] p, string tag);
        exp_t e;
        @(negedge clk);
        op_i = op;
        pred_i = p;
        e.cyc = cyc; e.ovf = 1'b0; e.udf = 1'b0; e.tag = tag;
        case (op)
            2'b01: if (m_stk.size() < DEPTH) begin
                       m_stk.push_back(m_mask);
                       m_mask = m_mask & p;
                   end else e.ovf = 1'b1;
            2'b10: if (m_stk.size() > 0) m_mask = m_stk[m_stk.size()-1] & ~m_mask;
                   else e.udf = 1'b1;
            2'b11: if (m_stk.size() > 0) m_mask = m_stk.pop_back();
                   else e.udf = 1'b1;
            default: ;
        endcase
        e.mask = m_mask;
        sb.push_back(e);
    endtask

    // monitor: compares each recorded expectation one edge after issue
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc < cyc) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " mask"}, act_mask_o, e.mask);
            check("R8 commit", commit_en_o, e.mask);
            check({e.tag, " ovf"}, {31'b0, ovf_o}, {31'b0, e.ovf});
            check({e.tag, " udf"}, {31'b0, udf_o}, {31'b0, e.udf});
            check("R9 all_off", {31'b0, all_off_o}, {31'b0, (e.mask == 32'h0)});
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        m_mask = '1;
        repeat (3) @(negedge clk);
        // R1: reset values seen while reset is held
        check("R1 mask", act_mask_o, 32'hFFFF_FFFF);
        check("R1 flags", {30'b0, ovf_o, udf_o}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mask after release", act_mask_o, 32'hFFFF_FFFF);
        // R1 empty stack, R6 / R7 underflow
        step(2'b11, 32'h0, "R6");
        step(2'b10, 32'h0, "R7");
        step(2'b00, 32'h0, "R10");
        // single if/else region: R2, R3, R4
        step(2'b01, 32'h0000_FFFF, "R2");
        step(2'b10, 32'h1234_5678, "R3");
        // nested region inside the else path
        step(2'b01, 32'h0F0F_0F0F, "R2");
        step(2'b00, 32'hFFFF_FFFF, "R10");
        step(2'b10, 32'h0, "R3");
        step(2'b11, 32'h0, "R4");
        step(2'b11, 32'h0, "R4");
        // branch no lane takes: R9
        step(2'b01, 32'h0000_0000, "R9");
        step(2'b10, 32'h0, "R3");
        step(2'b10, 32'h0, "R3");
        step(2'b11, 32'h0, "R4");
        // fill to DEPTH, then one more: R5
        for (int i = 0; i < DEPTH; i++)
            step(2'b01, ~(32'h1 << (i * 3)), "R2");
        step(2'b01, 32'h0, "R5");
        step(2'b01, 32'hFFFF_FFFF, "R5");
        step(2'b10, 32'h0, "R3");
        step(2'b10, 32'h0, "R3");
        for (int i = 0; i < DEPTH; i++)
            step(2'b11, 32'h0, "R4");
        step(2'b11, 32'h0, "R6");
        step(2'b10, 32'h0, "R7");
        step(2'b01, 32'hA5A5_A5A5, "R2");
        step(2'b00, 32'h0, "R10");
        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule